// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block chooses which of four DMA channels gets the next transfer slot. Each channel brings a request line and a 3-bit bandwidth code. The base ranking is fixed, and the lowest channel number wins. A code of zero on a channel lifts it one place, above its immediate lower-numbered neighbour. It never lifts it past any other channel. The codes are resolved from channel 1 upward. A channel whose neighbour has already been lifted keeps its own place. The result is a set of swaps between adjacent pairs that never overlap.

The winner is captured into a register as a one-hot grant, a binary index and a valid flag. The grant then stays fixed until the granted channel signals the end of its transfer. In the cycle after that signal the grant is cleared. The following cycle arbitrates again among the current requests. Requests that arrive together are ranked by the same ordering.

Top module: `dmaPrioArb`

## Requirements
- R1: After reset, grantOh is 0, grantIdx is 0 and grantValid is low.
- R2: While no grant is held and reqIn is all zero, the grant stays zero and grantValid stays low.
- R3: When no channel 1..3 has a bandwidth code of 3'b000, the requesting channel with the lowest number wins. Channel c's code is bwField[3c+2:3c].
- R4: A channel c ≥ 1 with code 3'b000 is lifted when its neighbour c-1 has not itself been lifted. Channels c and c-1 then swap places in the ranking, and no other channel moves.
- R5: When channel c-1 has already been lifted, a 3'b000 code on channel c has no effect on the ranking. For example, with codes 3'b000 on channels 1 and 2 the ranking is 1, 0, 2, 3.
- R6: A 3'b000 code on channel 0 has no effect. Channels with equal non-zero codes, or with different non-zero codes, keep the base ranking.
- R7: With no grant held and any request active, the grant for the winner appears one clock later. grantOh has exactly the bit grantIdx set, and grantValid is high.
- R8: While a grant is held and xferDone is low, grantOh, grantIdx and grantValid stay unchanged, whatever reqIn and bwField do.
- R9: A held grant with xferDone high is cleared at the next clock. Arbitration among the requests then present produces a new grant one clock after that.
- R10: grantOh has at most one bit set, and grantValid is high exactly when grantOh is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 4 | Request per channel |
| bwField | input | 12 | Bandwidth code per channel, 3 bits each, channel 0 in the low bits |
| xferDone | input | 1 | The granted channel's transfer has ended |
| grantOh | output | 4 | One-hot registered grant |
| grantIdx | output | 2 | Index of the granted channel |
| grantValid | output | 1 | A grant is held |

## Verification
The hardest cases to reach are chains of zero codes on adjacent channels, where one lift suppresses the next. They matter most when the two channels of a swapped pair request together with the channel just outside the pair. Directed cases set the codes and request masks for each such chain and compare the winner against hand-worked indices. A long random run follows, weighted so that about a quarter of all codes are zero. While a grant is held, the bench changes requests and codes on purpose to show that the grant does not move.

// File: rtl/dmaArbPkg.sv
package dmaArbPkg;
  typedef struct packed {
    logic loadGrant;
    logic clearGrant;
  } arbStrobeT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arbStateT;
endpackage

// File: rtl/arbCtrl.sv
module arbCtrl
  import dmaArbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      anyReq,
  input  logic      xferDone,
  output arbStrobeT strobe
);
  arbStateT state, stateNext;

  always_comb begin
    strobe.loadGrant  = (state == ST_IDLE) && anyReq;
    strobe.clearGrant = (state == ST_BUSY) && xferDone;
    stateNext = state;
    if (strobe.loadGrant)  stateNext = ST_BUSY;
    if (strobe.clearGrant) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && xferDone) |=> (state == ST_IDLE)); // R9
  AST_IDLE_NOREQ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !anyReq) |=> (state == ST_IDLE)); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && !xferDone) |=> (state == ST_BUSY)); // R8
endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import dmaArbPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int BW_W   = 3,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CH-1:0]      reqIn,
  input  logic [NUM_CH*BW_W-1:0] bwField,
  input  arbStrobeT              strobe,
  output logic                   anyReq,
  output logic [NUM_CH-1:0]      grantOh,
  output logic [IDX_W-1:0]       grantIdx,
  output logic                   grantValid
);
  logic [NUM_CH-1:0] promoted;
  logic [IDX_W-1:0]  slotCh [NUM_CH];
  logic [IDX_W-1:0]  winIdx;
  logic              winFound;

  // a zero code lifts a channel above its neighbour unless that neighbour was lifted
  always_comb begin
    promoted = '0;
    for (int c = 1; c < NUM_CH; c++)
      promoted[c] = (bwField[c*BW_W +: BW_W] == '0) && !promoted[c-1];
  end

  // ranking slots: slot p holds the channel ranked p-th
  always_comb begin
    for (int p = 0; p < NUM_CH; p++) begin
      slotCh[p] = IDX_W'(p);
      if (p > 0 && promoted[p]) slotCh[p] = IDX_W'(p - 1);
    end
    for (int p = 0; p < NUM_CH - 1; p++)
      if (promoted[p+1]) slotCh[p] = IDX_W'(p + 1);
  end

  always_comb begin
    winFound = 1'b0;
    winIdx   = '0;
    for (int p = 0; p < NUM_CH; p++) begin
      if (!winFound && reqIn[slotCh[p]]) begin
        winFound = 1'b1;
        winIdx   = slotCh[p];
      end
    end
  end

  assign anyReq = |reqIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantOh    <= '0;
      grantIdx   <= '0;
      grantValid <= 1'b0;
    end else if (strobe.clearGrant) begin
      grantOh    <= '0;
      grantIdx   <= '0;
      grantValid <= 1'b0;
    end else if (strobe.loadGrant) begin
      grantOh    <= NUM_CH'(1) << winIdx;
      grantIdx   <= winIdx;
      grantValid <= 1'b1;
    end
  end

  AST_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOh)); // R10
  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == (grantOh != '0)); // R10
  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> grantOh[grantIdx]); // R7
  AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> (($past(reqIn) & grantOh) != '0)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !strobe.clearGrant) |=> ($stable(grantOh) && $stable(grantIdx))); // R8
endmodule

// File: rtl/dmaPrioArb.sv
module dmaPrioArb
  import dmaArbPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int BW_W   = 3,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CH-1:0]      reqIn,
  input  logic [NUM_CH*BW_W-1:0] bwField,
  input  logic                   xferDone,
  output logic [NUM_CH-1:0]      grantOh,
  output logic [IDX_W-1:0]       grantIdx,
  output logic                   grantValid
);
  arbStrobeT strobe;
  logic      anyReq;

  arbCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyReq   (anyReq),
    .xferDone (xferDone),
    .strobe   (strobe)
  );

  arbDatapath #(.NUM_CH(NUM_CH), .BW_W(BW_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .reqIn      (reqIn),
    .bwField    (bwField),
    .strobe     (strobe),
    .anyReq     (anyReq),
    .grantOh    (grantOh),
    .grantIdx   (grantIdx),
    .grantValid (grantValid)
  );
endmodule

// File: tb/dmaPrioArb_test.sv
`timescale 1ns/1ps
module dmaPrioArb_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  reqIn = '0;
  logic [11:0] bwField = '0;
  logic        xferDone = 1'b0;
  logic [3:0]  grantOh;
  logic [1:0]  grantIdx;
  logic        grantValid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R7";

  // reference model state
  logic refBusy = 1'b0;
  int   refIdx = 0;

  dmaPrioArb uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .bwField(bwField), .xferDone(xferDone),
    .grantOh(grantOh), .grantIdx(grantIdx), .grantValid(grantValid)
  );

  always #2.5 clk = ~clk;

  function automatic logic [11:0] mkBw(int c0, int c1, int c2, int c3);
    return {3'(c3), 3'(c2), 3'(c1), 3'(c0)};
  endfunction

  // behavioural ranking: list of channels, lifted pairs swapped, scanning upward
  function automatic int refWinner(logic [3:0] req, logic [11:0] bw);
    int rank[$];
    bit lifted[4];
    for (int c = 0; c < 4; c++) begin rank.push_back(c); lifted[c] = 0; end
    for (int c = 1; c < 4; c++) begin
      if (bw[c*3 +: 3] == 3'b000 && !lifted[c-1]) begin
        int tmp = rank[c-1];
        rank[c-1] = rank[c];
        rank[c] = tmp;
        lifted[c] = 1;
      end
    end
    foreach (rank[k]) if (req[rank[k]]) return rank[k];
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      refBusy <= 1'b0;
      refIdx  <= 0;
    end else if (refBusy) begin
      if (xferDone) refBusy <= 1'b0;
    end else if (reqIn != 0) begin
      refBusy <= 1'b1;
      refIdx  <= refWinner(reqIn, bwField);
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check(grantValid == refBusy, curReq, "valid", int'(grantValid), int'(refBusy));
      if (refBusy) begin
        check(grantIdx == 2'(refIdx), curReq, "idx", int'(grantIdx), refIdx);
        check(grantOh == (4'b1 << refIdx), "R10", "onehot", int'(grantOh), 1 << refIdx);
      end else begin
        check(grantOh == 4'b0, "R10", "onehot idle", int'(grantOh), 0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic runCase(logic [3:0] req, logic [11:0] bw, int expIdx, string tag);
    curReq = tag;
    @(posedge clk); #1 reqIn = req; bwField = bw; xferDone = 1'b0;
    @(posedge clk); #1
    check(grantValid == 1'b1, tag, "valid", int'(grantValid), 1);
    check(int'(grantIdx) == expIdx, tag, "winner", int'(grantIdx), expIdx);
    xferDone = 1'b1;
    @(posedge clk); #1 xferDone = 1'b0; reqIn = '0;
    check(grantValid == 1'b0, "R9", "cleared", int'(grantValid), 0);
  endtask

  initial begin
    @(posedge clk); #1
    rstN = 1'b0;
    @(posedge clk); #1
    check(grantOh == 0 && grantIdx == 0 && grantValid == 0, "R1", "reset", int'(grantOh), 0);
    rstN = 1'b1;

    curReq = "R2";
    repeat (3) @(posedge clk);
    #1 check(grantValid == 1'b0, "R2", "no request", int'(grantValid), 0);

    runCase(4'b1111, mkBw(5,5,5,5), 0, "R3");
    runCase(4'b1100, mkBw(5,5,5,5), 2, "R3");
    runCase(4'b1010, mkBw(1,2,3,4), 1, "R3");
    runCase(4'b1100, mkBw(5,5,5,0), 3, "R4");
    runCase(4'b1010, mkBw(5,5,5,0), 1, "R4");
    runCase(4'b1111, mkBw(5,5,5,0), 0, "R4");
    runCase(4'b0011, mkBw(5,0,5,5), 1, "R4");
    runCase(4'b1111, mkBw(5,0,0,5), 1, "R5");
    runCase(4'b1101, mkBw(5,0,0,5), 0, "R5");
    runCase(4'b1110, mkBw(5,5,0,0), 2, "R5");
    runCase(4'b1010, mkBw(5,5,0,0), 1, "R5");
    runCase(4'b0011, mkBw(0,5,5,5), 0, "R6");
    runCase(4'b0110, mkBw(7,7,7,7), 1, "R6");

    // R8: grant held while requests and codes change
    curReq = "R8";
    @(posedge clk); #1 reqIn = 4'b0100; bwField = mkBw(5,5,5,5);
    @(posedge clk); #1 reqIn = 4'b1011; bwField = mkBw(5,0,5,0);
    for (int k = 0; k < 4; k++) begin
      check(grantIdx == 2'd2 && grantValid, "R8", "held", int'(grantIdx), 2);
      @(posedge clk); #1 reqIn = 4'(k + 1);
    end
    // R9: release with requests still pending, then re-arbitrate
    reqIn = 4'b1011; bwField = mkBw(5,0,5,0); xferDone = 1'b1;
    @(posedge clk); #1 xferDone = 1'b0; curReq = "R9";
    check(grantValid == 1'b0, "R9", "gap cycle", int'(grantValid), 0);
    @(posedge clk); #1
    check(grantIdx == 2'd1 && grantValid, "R9", "rearbitrate", int'(grantIdx), 1);
    xferDone = 1'b1;
    @(posedge clk); #1 xferDone = 1'b0; reqIn = '0;

    // random phase, zero codes weighted in
    curReq = "R7";
    for (int n = 0; n < 600; n++) begin
      @(posedge clk); #1
      reqIn = 4'($urandom_range(0, 15));
      for (int c = 0; c < 4; c++)
        bwField[c*3 +: 3] = ($urandom_range(0, 3) == 0) ? 3'b000 : 3'($urandom_range(1, 7));
      xferDone = ($urandom_range(0, 9) < 3);
    end
    @(posedge clk); #1 reqIn = '0; xferDone = 1'b1;
    repeat (3) @(posedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule